// File: doc/BRIEF.md
# FSK Word Serial Output Interface

This block sits behind an FSK demodulator and hands the recovered bit stream to a host over three wires: a serial data output, a host-driven read clock and an active-low ready strobe. A mode input picks one of two ways of working. With the mode input low, the demodulated bits go straight to the data output and the host needs no clock. With the mode input high, the block frames the asynchronous stream (start bit, eight data bits, stop bit) into words. It parks each good word in a shift register and pulls ready low. The host then shifts the word out with its read clock, least significant bit first.

Two qualifying inputs decide whether the demodulator output is believed at all. The first is an active-low carrier-present flag. The second is an enable that turns FSK reception off while tones, speech or alerts share the band. When either one reports "no signal", the pass-through output idles high, framing stops, and the shift register and ready strobe stay as they are.

The host read clock is asynchronous to the block. It passes through a two-flop synchroniser, and only its synchronised rising edges have an effect. Bit timing comes from a parameter giving system clocks per bit. At 1200 baud, the ready timeout of half a bit is about 417 µs.

Top module: `fsk_word_out`

## Requirements
- R1: After reset, data_out is 1 and ready_n is 1.
- R2: With mode_sel = 0, fsk_en = 1 and carrier_n = 0, data_out equals demod_bit with no clocked delay.
- R3: With mode_sel = 0, data_out is 1 whenever carrier_n = 1 or fsk_en = 0, whatever demod_bit is.
- R4: With mode_sel = 1 and the channel active, a frame is accepted in four steps. A falling edge on demod_bit starts it. The start bit is confirmed at mid-bit. Eight data bits are then sampled at mid-bit, the first received going into bit 0. A stop bit of 1 loads the word and drives ready_n low.
- R5: In mode 1, each synchronised rising edge of host_clk moves the next word bit onto data_out, bit 0 first. data_out changes only on such an edge.
- R6: A host_clk rising edge while ready_n is low returns ready_n high on the third system clock after the edge is seen at the input.
- R7: With no host_clk edge, ready_n stays low for exactly CLKS_PER_BIT/2 system clocks and then returns high.
- R8: Once all eight bits have been read, further host_clk edges leave data_out at the last bit read and leave ready_n high.
- R9: With mode_sel = 1 and carrier_n = 1 (or fsk_en = 0), no frame is loaded and ready_n does not fall. The unread part of a word already in the shift register is kept.
- R10: A frame whose stop bit samples 0 is discarded, and ready_n does not fall.
- R11: A low pulse on demod_bit shorter than half a bit is not taken as a start bit, so no word is loaded.
- R12: With mode_sel = 0, ready_n stays high, even if framed data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0: pass-through, 1: framed words read by host |
| fsk_en | input | 1 | FSK reception enable, high to accept data |
| carrier_n | input | 1 | Carrier present, active low |
| demod_bit | input | 1 | Demodulated serial bit stream, synchronous to clk |
| host_clk | input | 1 | Host read clock, asynchronous |
| data_out | output | 1 | Serial data to host |
| ready_n | output | 1 | Word ready strobe, active low |

## Verification
The hardest case to reach is a host read clock that arrives while ready is still low. The bench has to find the short window after the stop-bit sample, inside the stop bit, and raise host_clk there. The frame-sending task therefore watches ready_n through the stop bit and raises the read clock on the first sample where it sees ready_n low. It then measures how long ready_n stayed low, which separates release by the read clock (three cycles) from release by the timeout (half a bit). A second hard case is a word that is half read when the carrier drops. The bench reads four bits, sends a full frame with the carrier off, brings the carrier back, and checks that the last four bits still belong to the first word.

// File: rtl/fsk_out_pkg.sv
package fsk_out_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } fr_state_e;

    // Idle level of the pass-through output when the channel is not qualified
    function automatic logic gate_idle(input logic active, input logic bit_in);
        return active ? bit_in : 1'b1;
    endfunction

endpackage

// File: rtl/fsk_edge_sync.sv
module fsk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], async_in};
        end
    end

    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/fsk_frame_rx.sv
module fsk_frame_rx
    import fsk_out_pkg::*;
#(
    parameter int WORD_W       = 8,
    parameter int CLKS_PER_BIT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              rx_bit,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam int IDX_W = $clog2(WORD_W) + 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(WORD_W - 1);

    fr_state_e          st;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [WORD_W-1:0]  shreg;
    logic               prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= FR_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            prev  <= 1'b1;
        end else if (!run) begin
            st   <= FR_IDLE;
            cnt  <= '0;
            idx  <= '0;
            prev <= rx_bit;
        end else begin
            prev <= rx_bit;
            unique case (st)
                FR_IDLE: begin
                    if (prev && !rx_bit) begin
                        st  <= FR_START;
                        cnt <= '0;
                    end
                end
                FR_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt <= '0;
                        idx <= '0;
                        st  <= rx_bit ? FR_IDLE : FR_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_DATA: begin
                    if (cnt == FULL_LAST) begin
                        cnt   <= '0;
                        shreg <= {rx_bit, shreg[WORD_W-1:1]};
                        if (idx == IDX_LAST) st <= FR_STOP;
                        else idx <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_STOP: begin
                    if (cnt == FULL_LAST) begin
                        cnt <= '0;
                        st  <= FR_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= FR_IDLE;
            endcase
        end
    end

    assign word_valid = run && (st == FR_STOP) && (cnt == FULL_LAST) && rx_bit;
    assign word       = shreg;

endmodule

// File: rtl/fsk_read_port.sv
module fsk_read_port #(
    parameter int WORD_W   = 8,
    parameter int HOLD_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              rd_rise,
    output logic              data_bit,
    output logic              dr_n
);
    localparam int LEFT_W = $clog2(WORD_W + 1);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sreg;
        logic [LEFT_W-1:0] left;
        logic [HOLD_W-1:0] hold;
        logic              out_bit;
        logic              dr_n;
    } rd_state_t;

    rd_state_t s;

    always_ff @(posedge clk) begin
        if (rst) begin
            s.sreg    <= '0;
            s.left    <= '0;
            s.hold    <= '0;
            s.out_bit <= 1'b1;
            s.dr_n    <= 1'b1;
        end else if (load) begin
            s.sreg <= load_word;
            s.left <= LEFT_W'(WORD_W);
            s.hold <= '0;
            s.dr_n <= 1'b0;
        end else begin
            if (rd_rise && (s.left != '0)) begin
                s.out_bit <= s.sreg[0];
                s.sreg    <= s.sreg >> 1;
                s.left    <= s.left - 1'b1;
            end
            if (!s.dr_n) begin
                if (rd_rise || !mode_sel || (s.hold == HOLD_LAST)) s.dr_n <= 1'b1;
                else s.hold <= s.hold + 1'b1;
            end
        end
    end

    assign data_bit = s.out_bit;
    assign dr_n     = s.dr_n;

endmodule

// File: rtl/fsk_word_out.sv
module fsk_word_out
    import fsk_out_pkg::*;
#(
    parameter int CLKS_PER_BIT = 32,
    parameter int WORD_W       = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_sel,
    input  logic fsk_en,
    input  logic carrier_n,
    input  logic demod_bit,
    input  logic host_clk,
    output logic data_out,
    output logic ready_n
);
    localparam int HOLD_CYC = CLKS_PER_BIT / 2;

    logic              active;
    logic              run;
    logic              dclk_rise;
    logic              word_valid;
    logic [WORD_W-1:0] word;
    logic              rd_bit;

    assign active = fsk_en & ~carrier_n;
    assign run    = mode_sel & active;

    fsk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (host_clk),
        .rise     (dclk_rise)
    );

    fsk_frame_rx #(.WORD_W(WORD_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .rx_bit     (demod_bit),
        .word_valid (word_valid),
        .word       (word)
    );

    fsk_read_port #(.WORD_W(WORD_W), .HOLD_CYC(HOLD_CYC)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .load      (word_valid),
        .load_word (word),
        .rd_rise   (dclk_rise),
        .data_bit  (rd_bit),
        .dr_n      (ready_n)
    );

    assign data_out = mode_sel ? rd_bit : gate_idle(active, demod_bit);

endmodule

// File: rtl/fsk_word_out_chk.sv
module fsk_word_out_chk #(
    parameter int HOLD_CYC = 16
) (
    input logic clk,
    input logic rst,
    input logic mode_sel,
    input logic active,
    input logic dclk_rise,
    input logic ready_n,
    input logic data_out
);
    localparam int LOW_W = $clog2(HOLD_CYC + 2) + 1;

    logic [LOW_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || ready_n) low_cnt <= '0;
        else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
    end

    AST_IDLE_HIGH_MODE0: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && !active) |-> data_out);  // R3

    AST_NO_READY_MODE0: assert property (@(posedge clk) disable iff (rst)
        !mode_sel |=> ready_n);  // R12

    AST_READY_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_n) |-> $past(mode_sel && active));  // R9

    AST_FIRST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!ready_n && dclk_rise) |=> ready_n);  // R6

    AST_READY_LOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LOW_W'(HOLD_CYC));  // R7

    AST_DATA_MOVES_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && $past(mode_sel) && !$stable(data_out)) |-> $past(dclk_rise));  // R5

endmodule

bind fsk_word_out fsk_word_out_chk #(.HOLD_CYC(CLKS_PER_BIT / 2)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .active    (active),
    .dclk_rise (dclk_rise),
    .ready_n   (ready_n),
    .data_out  (data_out)
);

// File: tb/sim_fsk_word_out.sv
module sim_fsk_word_out;
    localparam int CPB  = 32;
    localparam int HALF = CPB / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b0;
    logic fsk_en = 1'b1;
    logic carrier_n = 1'b0;
    logic demod_bit = 1'b1;
    logic host_clk = 1'b0;
    logic data_out;
    logic ready_n;

    int runs = 0;
    int fails = 0;
    bit done = 1'b0;

    int dr_events = 0;
    int cur_low = 0;
    int last_low = 0;
    logic prev_rdy = 1'b1;

    always #2 clk = ~clk;

    fsk_word_out #(.CLKS_PER_BIT(CPB), .WORD_W(8), .SYNC_STAGES(2)) u0 (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .fsk_en    (fsk_en),
        .carrier_n (carrier_n),
        .demod_bit (demod_bit),
        .host_clk  (host_clk),
        .data_out  (data_out),
        .ready_n   (ready_n)
    );

    // Observe ready strobe at the ports: count falls and measure low time
    always @(negedge clk) begin
        if (!rst) begin
            if (!ready_n) begin
                if (prev_rdy) begin
                    dr_events = dr_events + 1;
                    cur_low = 0;
                end
                cur_low = cur_low + 1;
            end else if (!prev_rdy) begin
                last_low = cur_low;
            end
            prev_rdy = ready_n;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] w, input logic stop_v, input bit early);
        bit pulsed = 1'b0;
        @(negedge clk) demod_bit = 1'b0;
        idle(CPB - 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) demod_bit = w[i];
            idle(CPB - 1);
        end
        @(negedge clk) demod_bit = stop_v;
        for (int i = 0; i < CPB - 1; i++) begin
            @(negedge clk);
            if (early && !pulsed && !ready_n) begin
                host_clk = 1'b1;
                pulsed = 1'b1;
            end
        end
        @(negedge clk) demod_bit = 1'b1;
        if (pulsed) host_clk = 1'b0;
        idle(CPB);
    endtask

    task automatic rd_pulse();
        @(negedge clk) host_clk = 1'b1;
        idle(4);
        @(negedge clk) host_clk = 1'b0;
        idle(4);
    endtask

    task automatic t_reset();
        idle(1);
        chk("R1 data_out after reset", int'(data_out), 1);
        chk("R1 ready_n after reset", int'(ready_n), 1);
    endtask

    task automatic t_mode0();
        int ev;
        mode_sel = 1'b0; fsk_en = 1'b1; carrier_n = 1'b0;
        @(negedge clk) demod_bit = 1'b0; #1;
        chk("R2 pass-through 0", int'(data_out), 0);
        demod_bit = 1'b1; #1;
        chk("R2 pass-through 1", int'(data_out), 1);
        demod_bit = 1'b0; carrier_n = 1'b1; #1;
        chk("R3 no carrier forces high", int'(data_out), 1);
        carrier_n = 1'b0; fsk_en = 1'b0; #1;
        chk("R3 disabled forces high", int'(data_out), 1);
        fsk_en = 1'b1; #1;
        chk("R2 pass-through after enable", int'(data_out), 0);
        demod_bit = 1'b1;
        ev = dr_events;
        send_frame(8'h5A, 1'b1, 1'b0);
        chk("R12 no ready in mode 0", dr_events - ev, 0);
    endtask

    task automatic t_timeout_read();
        int ev;
        logic [7:0] w = 8'hA5;
        mode_sel = 1'b1;
        idle(4);
        ev = dr_events;
        send_frame(w, 1'b1, 1'b0);
        chk("R4 word loaded ready fell once", dr_events - ev, 1);
        chk("R7 ready low half bit", last_low, HALF);
        for (int i = 0; i < 8; i++) begin
            rd_pulse();
            chk("R5 read bit", int'(data_out), int'(w[i]));
        end
        rd_pulse();
        rd_pulse();
        chk("R8 extra reads keep last bit", int'(data_out), int'(w[7]));
        chk("R8 extra reads keep ready high", int'(ready_n), 1);
    endtask

    task automatic t_early_read();
        int ev;
        logic [7:0] w = 8'h3C;
        ev = dr_events;
        send_frame(w, 1'b1, 1'b1);
        chk("R4 second word loaded", dr_events - ev, 1);
        chk("R6 first read releases ready", last_low, 3);
        chk("R5 first bit from early read", int'(data_out), int'(w[0]));
        for (int i = 1; i < 8; i++) begin
            rd_pulse();
            chk("R5 read bit after early", int'(data_out), int'(w[i]));
        end
    endtask

    task automatic t_inactive();
        int ev;
        logic [7:0] w = 8'h96;
        send_frame(w, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            rd_pulse();
            chk("R5 partial read", int'(data_out), int'(w[i]));
        end
        carrier_n = 1'b1;
        ev = dr_events;
        send_frame(8'h0F, 1'b1, 1'b0);
        chk("R9 no ready without carrier", dr_events - ev, 0);
        fsk_en = 1'b0; carrier_n = 1'b0;
        send_frame(8'hF0, 1'b1, 1'b0);
        chk("R9 no ready when disabled", dr_events - ev, 0);
        fsk_en = 1'b1;
        idle(4);
        for (int i = 4; i < 8; i++) begin
            rd_pulse();
            chk("R9 old word kept", int'(data_out), int'(w[i]));
        end
    endtask

    task automatic t_bad_stop();
        int ev;
        ev = dr_events;
        send_frame(8'h55, 1'b0, 1'b0);
        idle(CPB);
        chk("R10 bad stop discarded", dr_events - ev, 0);
    endtask

    task automatic t_glitch();
        int ev;
        ev = dr_events;
        @(negedge clk) demod_bit = 1'b0;
        idle(HALF / 2);
        @(negedge clk) demod_bit = 1'b1;
        idle(12 * CPB);
        chk("R11 short low not a start", dr_events - ev, 0);
        send_frame(8'hC3, 1'b1, 1'b0);
        chk("R4 frame after glitch", dr_events - ev, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mode0();
        t_timeout_read();
        t_early_read();
        t_inactive();
        t_bad_stop();
        t_glitch();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

endmodule